// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Control

This block is the control logic that keeps a five-stage in-order integer pipeline correct when instructions in flight depend on one another. It watches register numbers and write enables across the stages. For each of the two ALU operands of the instruction in execute, it picks where the operand comes from: the register-file read, the result now in the memory stage, or the result now in writeback. The datapath muxes take these selects directly.

It also watches the instruction in decode. If that instruction reads a register that a load in execute will write, the loaded value cannot reach it in time. The unit then raises a stall, which holds the program counter and the fetch/decode register, and a bubble request, which clears the control bits entering execute. The hold lasts exactly one cycle.

A producer that has reached writeback needs no action when its consumer is in decode. The register file writes early in the cycle and reads late, so decode sees the new value. The unit is purely combinational. It sits beside the pipeline registers, which belong to the datapath.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the memory stage writes a nonzero register equal to an execute source, that operand's select is 2'b10 (memory-stage result).
- R2: When the writeback stage writes a nonzero register equal to an execute source and the memory stage does not, that operand's select is 2'b01 (writeback result).
- R3: When both later stages write the register named by an execute source, the select is 2'b10, so the newer memory-stage value wins.
- R4: With no matching write, or with the matching stage's write enable low, the select is 2'b00 (register file). The value 2'b11 never appears.
- R5: Register 0 is never forwarded and never causes a stall, whatever the stage destinations hold.
- R6: Operand A's select follows only the first execute source and operand B's select only the second, so the two selects may differ.
- R7: Stall and bubble are both 1 when the execute instruction has its load flag and write enable set, its destination is nonzero, and that destination equals either decode source.
- R8: A non-load producer in execute never causes a stall, because its result is bypassed.
- R9: A load-use dependency costs exactly one stall cycle. After the bubble, the consumer in execute takes operand select 2'b01 from the load in writeback.
- R10: A producer in writeback whose destination matches a decode source causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs1 | input | REG_W | First source register of the decode-stage instruction |
| id_rs2 | input | REG_W | Second source register of the decode-stage instruction |
| ex_rs1 | input | REG_W | First source register of the execute-stage instruction |
| ex_rs2 | input | REG_W | Second source register of the execute-stage instruction |
| ex_rd | input | REG_W | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Register write enable of the execute-stage instruction |
| ex_load | input | 1 | Execute-stage instruction is a memory load |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Register write enable of the memory-stage instruction |
| wb_rd | input | REG_W | Destination register of the writeback-stage instruction |
| wb_we | input | 1 | Register write enable of the writeback-stage instruction |
| fwd_a | output | 2 | Operand A source select: 00 register file, 10 memory stage, 01 writeback |
| fwd_b | output | 2 | Operand B source select, same encoding as fwd_a |
| stall | output | 1 | Hold the program counter and the fetch/decode register |
| bubble | output | 1 | Clear the control bits loaded into the decode/execute register |

## Verification
The assertions check several properties on every input combination. The selects are never 2'b11. Register 0 always yields the register-file select. The memory stage takes priority whenever it matches. A writeback select never appears without a matching writeback write that the memory stage does not shadow. A stall never appears without a load in execute that targets a decode source. Only the bench's scenarios can show three things: that the interlock lasts one cycle across a load, bubble, consumer sequence; that the consumer then picks up the writeback result; and that dependencies at writeback distance pass with neither a stall nor a bypass.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;

  // Operand source select driven to the execute-stage ALU input muxes
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } opnd_src_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_src_match.sv
`timescale 1ns/1ps
// Picks the bypass source for one execute-stage operand.
module fwd_src_match
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output opnd_src_e        sel
);

  logic src_live;
  logic mem_hit;
  logic wb_hit;

  assign src_live = (src != '0);
  assign mem_hit  = src_live && mem_we && (mem_rd == src);
  assign wb_hit   = src_live && wb_we  && (wb_rd  == src);

  // The newer result (memory stage) is checked first.
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_REGFILE;
  end

endmodule

// File: rtl/load_use_detect.sv
`timescale 1ns/1ps
// Flags a decode-stage read of a register that a load in execute will write.
module load_use_detect #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
  input  logic [REG_W-1:0]              ex_rd,
  input  logic                          ex_we,
  input  logic                          ex_load,
  output logic                          hit
);

  logic             producer_ok;
  logic [NUM_SRC-1:0] src_hit;

  assign producer_ok = ex_load && ex_we && (ex_rd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = producer_ok && (id_src[g] == ex_rd);
  end

  assign hit = |src_hit;

endmodule

// File: rtl/hazard_fwd_unit.sv
`timescale 1ns/1ps
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble
);

  logic [NUM_OPND-1:0][REG_W-1:0] ex_src;
  logic [NUM_OPND-1:0][REG_W-1:0] id_src;
  opnd_src_e                      sel [NUM_OPND];
  logic                           lu_hit;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_src_match #(.REG_W(REG_W)) u_match (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel[g])
    );
  end

  load_use_detect #(.REG_W(REG_W), .NUM_SRC(NUM_OPND)) u_lu (
    .id_src  (id_src),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_load (ex_load),
    .hit     (lu_hit)
  );

  assign fwd_a  = sel[0];
  assign fwd_b  = sel[1];
  assign stall  = lu_hit;
  assign bubble = lu_hit;

endmodule

// File: rtl/hazard_fwd_chk.sv
`timescale 1ns/1ps
module hazard_fwd_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_we,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_we,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_we,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             stall,
  input logic             bubble
);

  always_comb begin
    // R4
    sel_legal_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    // R5
    zero_src_chk: assert ((ex_rs1 != '0 || fwd_a == 2'b00) &&
                          (ex_rs2 != '0 || fwd_b == 2'b00));
    // R3
    mem_priority_chk: assert (!(mem_we && mem_rd == ex_rs1 && ex_rs1 != '0) ||
                              fwd_a == 2'b10);
    // R2
    wb_source_chk: assert (fwd_b != 2'b01 ||
                           (wb_we && wb_rd == ex_rs2 &&
                            !(mem_we && mem_rd == ex_rs2)));
    // R7
    stall_cause_chk: assert (!stall ||
                             (ex_load && ex_we && ex_rd != '0 &&
                              (ex_rd == id_rs1 || ex_rd == id_rs2)));
    // R7
    bubble_cause_chk: assert (!bubble || (ex_load && ex_we));
  end

endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_W(REG_W)) u_chk (
  .id_rs1 (id_rs1), .id_rs2 (id_rs2), .ex_rs1 (ex_rs1), .ex_rs2 (ex_rs2),
  .ex_rd  (ex_rd),  .ex_we  (ex_we),  .ex_load (ex_load),
  .mem_rd (mem_rd), .mem_we (mem_we), .wb_rd (wb_rd), .wb_we (wb_we),
  .fwd_a  (fwd_a),  .fwd_b  (fwd_b),  .stall (stall), .bubble (bubble)
);

// File: tb/hazard_fwd_unit_bench.sv
`timescale 1ns/1ps
module hazard_fwd_unit_bench;

  localparam int unsigned REG_W = 5;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [REG_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_load, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;

  int nchk  = 0;
  int nfail = 0;
  int cycles = 0;

  hazard_fwd_unit #(.REG_W(REG_W)) u_hazard_fwd_unit (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
  );

  // {ex_rs1, ex_rs2, mem_rd, mem_we, wb_rd, wb_we, exp_a, exp_b}
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {5'd1,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00}, // R4
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00}, // R1
    {5'd3,  5'd4,  5'd4,  1'b1, 5'd0,  1'b0, 2'b00, 2'b10}, // R1 R6
    {5'd5,  5'd6,  5'd0,  1'b0, 5'd5,  1'b1, 2'b01, 2'b00}, // R2
    {5'd5,  5'd6,  5'd0,  1'b0, 5'd6,  1'b1, 2'b00, 2'b01}, // R2
    {5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 2'b10, 2'b10}, // R3
    {5'd8,  5'd9,  5'd8,  1'b1, 5'd9,  1'b1, 2'b10, 2'b01}, // R6
    {5'd8,  5'd9,  5'd8,  1'b0, 5'd8,  1'b0, 2'b00, 2'b00}, // R4
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5
    {5'd31, 5'd1,  5'd31, 1'b0, 5'd31, 1'b1, 2'b01, 2'b00}, // R2
    {5'd12, 5'd12, 5'd13, 1'b1, 5'd12, 1'b1, 2'b01, 2'b01}, // R2
    {5'd0,  5'd14, 5'd0,  1'b1, 5'd14, 1'b1, 2'b00, 2'b01}  // R5
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_we, ex_load, mem_we, wb_we} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      finish_run();
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    // idle state, all stages empty (R4)
    chk("R4 idle fwd_a", fwd_a, 2'b00);
    chk("R4 idle fwd_b", fwd_b, 2'b00);
    chk("R7 idle stall", {1'b0, stall}, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {ex_rs1, ex_rs2, mem_rd, mem_we, wb_rd, wb_we} = VEC[i][25:4];
      #2;
      chk($sformatf("R1-table[%0d] fwd_a", i), fwd_a, VEC[i][3:2]);
      chk($sformatf("R1-table[%0d] fwd_b", i), fwd_b, VEC[i][1:0]);
      chk($sformatf("R8 table[%0d] stall", i), {1'b0, stall}, 2'b00);
    end

    // R7: load in execute feeds first decode source
    clear_inputs();
    ex_rd = 5'd5; ex_we = 1'b1; ex_load = 1'b1; id_rs1 = 5'd5; id_rs2 = 5'd1;
    settle();
    chk("R7 rs1 stall", {1'b0, stall}, 2'b01);
    chk("R7 rs1 bubble", {1'b0, bubble}, 2'b01);
    // R7: second decode source
    id_rs1 = 5'd2; id_rs2 = 5'd5;
    settle();
    chk("R7 rs2 stall", {bubble, stall}, 2'b11);
    // R7: no match
    id_rs2 = 5'd6;
    settle();
    chk("R7 nomatch stall", {bubble, stall}, 2'b00);
    // R8: ALU producer
    ex_load = 1'b0; id_rs1 = 5'd5;
    settle();
    chk("R8 alu producer", {bubble, stall}, 2'b00);
    // R5: load to register 0
    ex_load = 1'b1; ex_rd = 5'd0; id_rs1 = 5'd0; id_rs2 = 5'd0;
    settle();
    chk("R5 load x0", {bubble, stall}, 2'b00);
    // R10: writeback producer, consumer in decode
    clear_inputs();
    wb_rd = 5'd7; wb_we = 1'b1; id_rs1 = 5'd7; id_rs2 = 5'd7;
    settle();
    chk("R10 wb distance stall", {bubble, stall}, 2'b00);
    chk("R10 wb distance fwd_a", fwd_a, 2'b00);

    // R9: load / consumer sequence across three cycles
    clear_inputs();
    ex_rd = 5'd9; ex_we = 1'b1; ex_load = 1'b1; id_rs1 = 5'd9; id_rs2 = 5'd3;
    settle();
    chk("R9 cycle1 stall", {bubble, stall}, 2'b11);
    // bubble in execute, load in memory, consumer held in decode
    clear_inputs();
    mem_rd = 5'd9; mem_we = 1'b1; id_rs1 = 5'd9; id_rs2 = 5'd3;
    settle();
    chk("R9 cycle2 no stall", {bubble, stall}, 2'b00);
    // consumer in execute, bubble in memory, load in writeback
    clear_inputs();
    ex_rs1 = 5'd9; ex_rs2 = 5'd3; wb_rd = 5'd9; wb_we = 1'b1;
    settle();
    chk("R9 cycle3 fwd_a", fwd_a, 2'b01);
    chk("R9 cycle3 fwd_b", fwd_b, 2'b00);
    chk("R9 cycle3 stall", {bubble, stall}, 2'b00);

    finish_run();
  end

endmodule